// File: doc/BRIEF.md
# IDE Host Register Window Decoder

This block is the CPU-facing front end of a two-drive IDE host controller. A 4 KB memory-mapped window is split into 16-byte register slots. Each bus access carries a byte address and an access size in bytes. The block works out which slot is addressed and checks whether that slot accepts the given size. Legal accesses go to one of three places: the drive-side register file, a local timing register, or a local interrupt state register.

The drive-side register file covers the data port, the seven taskfile registers and the status/command register. It is reached through a simple strobe interface. Reads return data in the same cycle, combinationally. Writes to the local registers take effect at the next clock edge.

The interrupt state register holds an image of the disk interrupt and a sticky copy of the DMA interrupt. Software clears the sticky DMA bit by writing a one to it. Both interrupt inputs are also passed straight through to their own outputs.

Top module: `ide_regwin_top`

## Requirements
- R1: The slot index is bus_addr[11:4]. Address bits [3:0] do not affect decoding, so address 0x01F selects slot 1.
- R2: Slot 0 (data port) accepts sizes 2 and 4 only. A legal access pulses drv_rd or drv_wr with drv_idx=0, and drv_wide=1 only for size 4. Any other size produces no strobe. drv_rd and drv_wr are never high together.
- R3: Slots 1 to 7 accept size 1 only. A legal access strobes the drive port with drv_idx equal to the slot number. Sizes 2 and 4 produce no strobe.
- R4: Slots 8 and 0x16 both accept size 1 only. Each strobes the drive port with drv_idx=8: status on a read, command on a write.
- R5: Slot 0x20 is a 32-bit timing register that takes size 4 only. A write changes it at the next edge. A write of any other size leaves it unchanged.
- R6: Slot 0x30 reads as the interrupt state. Bit 30 equals the disk interrupt level sampled at the previous edge. Bit 31 is set at an edge where the DMA input has risen and cleared at an edge where it has fallen. All other bits read 0.
- R7: A size-4 write to slot 0x30 with bit 31 set clears bit 31. The other written bits have no effect, and other sizes are ignored. A DMA input edge in the same cycle takes priority over the clear.
- R8: A read of an unmapped slot, or of a mapped slot with an illegal size, returns 0xFFFFFFFF and strobes nothing.
- R9: Data is little-endian, with lane 0 in bits [7:0]. Size-1 reads return drv_rdata[7:0] zero-extended and size-2 reads return drv_rdata[15:0] zero-extended. drv_wdata carries bus_wdata masked to the access size.
- R10: dma_irq_out equals dma_irq_in and disk_irq_out equals disk_irq_in in the same cycle.
- R11: Reset clears the timing register and the interrupt state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address inside the window |
| bus_size | input | 3 | Access size in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| drv_rd | output | 1 | Drive register read strobe |
| drv_wr | output | 1 | Drive register write strobe |
| drv_idx | output | 4 | Drive register: 0 data, 1-7 taskfile, 8 status/command |
| drv_wide | output | 1 | 32-bit data port access |
| drv_wdata | output | 32 | Size-masked write data to drive |
| drv_rdata | input | 32 | Read data from drive |
| dma_irq_in | input | 1 | DMA interrupt level |
| disk_irq_in | input | 1 | Disk interrupt level |
| dma_irq_out | output | 1 | DMA interrupt forwarded |
| disk_irq_out | output | 1 | Disk interrupt forwarded |

## Verification
The properties assume that the bus signals are known whenever bus_valid is high. They also assume that the interrupt inputs change only between clock edges, so that each edge sees at most one transition per input. The stimulus follows both rules: it drives every input at the falling edge, one access per cycle, and changes each interrupt level at most once per cycle. It also pairs a DMA rise with a clear write in the same cycle to exercise the priority rule. The reference model is compared against the outputs on every cycle.

// File: rtl/ide_regwin_pkg.sv
// Package: shared slot numbers, target encoding and width constants for the
// IDE register window decoder. Assumes a 12-bit window address.
package ide_regwin_pkg;
    localparam int ADDR_W    = 12;
    localparam int DATA_W    = 32;
    localparam int SLOT_LSB  = 4;
    localparam int SLOT_W    = ADDR_W - SLOT_LSB;
    localparam int IDX_W     = 4;

    localparam logic [SLOT_W-1:0] SLOT_DATA    = 8'h00;
    localparam logic [SLOT_W-1:0] SLOT_TF_LO   = 8'h01;
    localparam logic [SLOT_W-1:0] SLOT_TF_HI   = 8'h07;
    localparam logic [SLOT_W-1:0] SLOT_STCMD_A = 8'h08;
    localparam logic [SLOT_W-1:0] SLOT_STCMD_B = 8'h16;
    localparam logic [SLOT_W-1:0] SLOT_TIMING  = 8'h20;
    localparam logic [SLOT_W-1:0] SLOT_IRQST   = 8'h30;

    localparam logic [IDX_W-1:0] IDX_STCMD = 4'd8;

    localparam int DMA_BIT  = DATA_W - 1;
    localparam int DISK_BIT = DATA_W - 2;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_DATA,
        TGT_TASK,
        TGT_STCMD,
        TGT_TIMING,
        TGT_IRQST
    } tgt_e;

    // Byte-lane mask for an access size in bytes (little-endian, lane 0 low).
    function automatic logic [DATA_W-1:0] size_mask(input logic [2:0] sz);
        case (sz)
            3'd1:    size_mask = {{(DATA_W-8){1'b0}}, 8'hFF};
            3'd2:    size_mask = {{(DATA_W-16){1'b0}}, 16'hFFFF};
            default: size_mask = {DATA_W{1'b1}};
        endcase
    endfunction
endpackage

// File: rtl/ide_regwin_decode.sv
// Slot decoder: extracts the slot index from the window address and
// classifies it into a target with a legal-size flag. Purely combinational;
// assumes bus_size is a byte count.
module ide_regwin_decode
    import ide_regwin_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int SL = SLOT_LSB
) (
    input  logic [AW-1:0]    addr,
    input  logic [2:0]       size,
    output logic [AW-SL-1:0] slot,
    output tgt_e             tgt,
    output logic             legal
);
    localparam int SW = AW - SL;

    logic sz1, sz2, sz4;

    // Slot index from the upper address bits.
    assign slot = addr[AW-1:SL];

    // Size class flags.
    always_comb begin
        sz1 = (size == 3'd1);
        sz2 = (size == 3'd2);
        sz4 = (size == 3'd4);
    end

    // Target and legality by slot.
    always_comb begin
        tgt   = TGT_NONE;
        legal = 1'b0;
        if (slot == SW'(SLOT_DATA)) begin
            tgt   = TGT_DATA;
            legal = sz2 | sz4;
        end else if (slot >= SW'(SLOT_TF_LO) && slot <= SW'(SLOT_TF_HI)) begin
            tgt   = TGT_TASK;
            legal = sz1;
        end else if (slot == SW'(SLOT_STCMD_A) || slot == SW'(SLOT_STCMD_B)) begin
            tgt   = TGT_STCMD;
            legal = sz1;
        end else if (slot == SW'(SLOT_TIMING)) begin
            tgt   = TGT_TIMING;
            legal = sz4;
        end else if (slot == SW'(SLOT_IRQST)) begin
            tgt   = TGT_IRQST;
            legal = sz4;
        end
    end
endmodule

// File: rtl/ide_regwin_drvport.sv
// Drive-side port: turns a legal decoded access to the data port, taskfile
// or status/command slot into a strobe with a register index, and
// size-masks data in both directions. Assumes the drive returns read data
// combinationally.
module ide_regwin_drvport
    import ide_regwin_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int SW = SLOT_W,
    parameter int IW = IDX_W
) (
    input  logic          valid,
    input  logic          write,
    input  tgt_e          tgt,
    input  logic          legal,
    input  logic [SW-1:0] slot,
    input  logic [2:0]    size,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] drv_rdata,
    output logic          drv_rd,
    output logic          drv_wr,
    output logic [IW-1:0] drv_idx,
    output logic          drv_wide,
    output logic [DW-1:0] drv_wdata,
    output logic [DW-1:0] port_rdata
);
    logic            hit;
    logic [DW-1:0]   mask;

    // Access targets the drive register file.
    assign hit = valid && legal &&
                 (tgt == TGT_DATA || tgt == TGT_TASK || tgt == TGT_STCMD);

    // Read and write strobes.
    always_comb begin
        drv_rd = hit && !write;
        drv_wr = hit && write;
    end

    // Register index selection.
    always_comb begin
        case (tgt)
            TGT_TASK:  drv_idx = IW'(slot[IW-1:0]);
            TGT_STCMD: drv_idx = IDX_STCMD;
            default:   drv_idx = '0;
        endcase
    end

    // Size mask and data lanes.
    always_comb begin
        mask       = size_mask(size);
        drv_wide   = hit && (tgt == TGT_DATA) && (size == 3'd4);
        drv_wdata  = wdata & mask;
        port_rdata = drv_rdata & mask;
    end
endmodule

// File: rtl/ide_regwin_word.sv
// Plain word register with synchronous active-low reset to zero and a
// load enable. Used for the timing register.
module ide_regwin_word #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Load on enable, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= d;
    end
endmodule

// File: rtl/ide_regwin_irq.sv
// Interrupt state register: the top bit is a sticky DMA flag set on a rising
// DMA level and cleared on a falling level or a software clear (edges win).
// The next bit is a sampled image of the disk level. Assumes the inputs are
// synchronous to clk.
module ide_regwin_irq
    import ide_regwin_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dma_lvl,
    input  logic          disk_lvl,
    input  logic          clr_req,
    output logic [DW-1:0] status
);
    logic dma_prev;
    logic dma_flag;
    logic disk_img;
    logic dma_rise, dma_fall;

    // Previous DMA level, tracked through reset as well.
    always_ff @(posedge clk) begin
        dma_prev <= dma_lvl;
    end

    // Edge detect.
    always_comb begin
        dma_rise = dma_lvl && !dma_prev;
        dma_fall = !dma_lvl && dma_prev;
    end

    // Sticky DMA flag with edge priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        dma_flag <= 1'b0;
        else if (dma_rise) dma_flag <= 1'b1;
        else if (dma_fall) dma_flag <= 1'b0;
        else if (clr_req)  dma_flag <= 1'b0;
    end

    // Disk level image.
    always_ff @(posedge clk) begin
        if (!rst_n) disk_img <= 1'b0;
        else        disk_img <= disk_lvl;
    end

    // Pack the status word.
    always_comb begin
        status           = '0;
        status[DMA_BIT]  = dma_flag;
        status[DISK_BIT] = disk_img;
    end
endmodule

// File: rtl/ide_regwin_top.sv
// IDE host register window decoder top: decodes slot and size, routes to the
// drive port, the timing register or the interrupt state register, and
// returns all-ones for anything unmapped or illegally sized. Assumes one
// access per cycle and reads completing in the same cycle.
module ide_regwin_top
    import ide_regwin_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_valid,
    input  logic        bus_write,
    input  logic [11:0] bus_addr,
    input  logic [2:0]  bus_size,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        drv_rd,
    output logic        drv_wr,
    output logic [3:0]  drv_idx,
    output logic        drv_wide,
    output logic [31:0] drv_wdata,
    input  logic [31:0] drv_rdata,
    input  logic        dma_irq_in,
    input  logic        disk_irq_in,
    output logic        dma_irq_out,
    output logic        disk_irq_out
);
    logic [SLOT_W-1:0] slot;
    tgt_e              tgt;
    logic              legal;
    logic [DATA_W-1:0] port_rdata;
    logic [DATA_W-1:0] timing_q;
    logic [DATA_W-1:0] irq_q;
    logic              timing_we;
    logic              irq_clr;

    ide_regwin_decode #(.AW(ADDR_W), .SL(SLOT_LSB)) u_dec (
        .addr (bus_addr),
        .size (bus_size),
        .slot (slot),
        .tgt  (tgt),
        .legal(legal)
    );

    ide_regwin_drvport #(.DW(DATA_W), .SW(SLOT_W), .IW(IDX_W)) u_port (
        .valid     (bus_valid),
        .write     (bus_write),
        .tgt       (tgt),
        .legal     (legal),
        .slot      (slot),
        .size      (bus_size),
        .wdata     (bus_wdata),
        .drv_rdata (drv_rdata),
        .drv_rd    (drv_rd),
        .drv_wr    (drv_wr),
        .drv_idx   (drv_idx),
        .drv_wide  (drv_wide),
        .drv_wdata (drv_wdata),
        .port_rdata(port_rdata)
    );

    // Local register write controls.
    always_comb begin
        timing_we = bus_valid && bus_write && legal && (tgt == TGT_TIMING);
        irq_clr   = bus_valid && bus_write && legal && (tgt == TGT_IRQST)
                    && bus_wdata[DMA_BIT];
    end

    ide_regwin_word #(.W(DATA_W)) u_timing (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (timing_we),
        .d    (bus_wdata),
        .q    (timing_q)
    );

    ide_regwin_irq #(.DW(DATA_W)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .dma_lvl (dma_irq_in),
        .disk_lvl(disk_irq_in),
        .clr_req (irq_clr),
        .status  (irq_q)
    );

    // Read data mux with all-ones default.
    always_comb begin
        bus_rdata = {DATA_W{1'b1}};
        if (legal) begin
            case (tgt)
                TGT_DATA, TGT_TASK, TGT_STCMD: bus_rdata = port_rdata;
                TGT_TIMING:                    bus_rdata = timing_q;
                TGT_IRQST:                     bus_rdata = irq_q;
                default:                       bus_rdata = {DATA_W{1'b1}};
            endcase
        end
    end

    // Interrupt pass-through.
    assign dma_irq_out  = dma_irq_in;
    assign disk_irq_out = disk_irq_in;
endmodule

// File: rtl/ide_regwin_chk.sv
// Checker for ide_regwin_top: temporal properties on ports and on the local
// register state, bound into every instance of the top.
module ide_regwin_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_valid,
    input logic        bus_write,
    input logic [11:0] bus_addr,
    input logic [2:0]  bus_size,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        drv_rd,
    input logic        drv_wr,
    input logic        dma_irq_in,
    input logic        disk_irq_in,
    input logic [31:0] timing_q,
    input logic [31:0] irq_q
);
    logic [7:0] s;
    logic       mapped;
    assign s      = bus_addr[11:4];
    assign mapped = (s <= 8'h08) || (s == 8'h16) || (s == 8'h20) || (s == 8'h30);

    // R2
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({drv_rd, drv_wr}));

    // R5
    timing_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && s == 8'h20 && bus_size == 3'd4)
        |=> (timing_q == $past(bus_wdata)));

    // R6
    disk_image_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_q[30] == $past(disk_irq_in)));

    // R6
    dma_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_irq_in && !$past(dma_irq_in)) |=> irq_q[31]);

    // R7
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && s == 8'h30 && bus_size == 3'd4 &&
         bus_wdata[31] && dma_irq_in == $past(dma_irq_in)) |=> !irq_q[31]);

    // R8
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && !mapped)
        |-> (bus_rdata == 32'hFFFF_FFFF && !drv_rd));

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (timing_q == 32'h0 && irq_q == 32'h0));
endmodule

bind ide_regwin_top ide_regwin_chk u_chk (.*);

// File: tb/sim_ide_regwin_top.sv
module sim_ide_regwin_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [2:0]  bus_size = 3'd4;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        drv_rd, drv_wr, drv_wide;
    logic [3:0]  drv_idx;
    logic [31:0] drv_wdata, drv_rdata;
    logic        dma_irq_in = 1'b0, disk_irq_in = 1'b0;
    logic        dma_irq_out, disk_irq_out;

    int errors = 0;
    int checks = 0;

    // Reference model state.
    logic [31:0] m_timing = '0;
    logic        m_dma = 1'b0, m_disk = 1'b0, m_prev = 1'b0;

    always #10 clk = ~clk;

    // Drive register file stand-in: value depends on the selected index.
    assign drv_rdata = 32'hC3A5_9600 | {28'h0, drv_idx};

    ide_regwin_top u0 (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // One bus cycle: drive at negedge, compare mid-cycle, update model at edge.
    task automatic cyc(input logic v, input logic w, input logic [11:0] a,
                       input logic [2:0] sz, input logic [31:0] wd,
                       input logic dma, input logic disk);
        int slot;
        bit lg, drvt;
        logic [3:0] idx;
        logic [31:0] msk, exp_rd;
        bit rise, fall;
        bus_valid = v; bus_write = w; bus_addr = a; bus_size = sz;
        bus_wdata = wd; dma_irq_in = dma; disk_irq_in = disk;
        #2;
        slot = int'(a >> 4);
        lg = 0; drvt = 0; idx = 0;
        if (slot == 0)                     begin lg = (sz == 2 || sz == 4); drvt = 1; end
        else if (slot >= 1 && slot <= 7)   begin lg = (sz == 1); drvt = 1; idx = 4'(slot); end
        else if (slot == 8 || slot == 22)  begin lg = (sz == 1); drvt = 1; idx = 4'd8; end
        else if (slot == 32 || slot == 48) lg = (sz == 4);
        msk = (sz == 1) ? 32'hFF : (sz == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
        // R10 pass-through
        chk("R10 dma_out", {31'h0, dma_irq_out}, {31'h0, dma});
        chk("R10 disk_out", {31'h0, disk_irq_out}, {31'h0, disk});
        // R2 R3 R4 R8 strobes
        chk("R2/R3/R4/R8 drv_rd", {31'h0, drv_rd}, {31'h0, v && !w && lg && drvt});
        chk("R2/R3/R4/R8 drv_wr", {31'h0, drv_wr}, {31'h0, v && w && lg && drvt});
        if (v && lg && drvt) begin
            chk("R1 R3 R4 drv_idx", {28'h0, drv_idx}, {28'h0, idx});
            chk("R2 drv_wide", {31'h0, drv_wide}, {31'h0, slot == 0 && sz == 4});
            if (w) chk("R9 drv_wdata", drv_wdata, wd & msk);
        end
        if (v && !w) begin
            if (!lg)              exp_rd = 32'hFFFF_FFFF;
            else if (drvt)        exp_rd = (32'hC3A5_9600 | {28'h0, idx}) & msk;
            else if (slot == 32)  exp_rd = m_timing;
            else                  exp_rd = {m_dma, m_disk, 30'h0};
            chk(lg ? "R9 R5 R6 rdata" : "R8 rdata", bus_rdata, exp_rd);
        end
        @(posedge clk);
        if (!rst_n) begin
            m_timing = '0; m_dma = 0; m_disk = 0;
        end else begin
            if (v && w && lg && slot == 32) m_timing = wd;
            rise = dma && !m_prev; fall = !dma && m_prev;
            if (rise) m_dma = 1;
            else if (fall) m_dma = 0;
            else if (v && w && lg && slot == 48 && wd[31]) m_dma = 0;
            m_disk = disk;
        end
        m_prev = dma;
        @(negedge clk);
    endtask

    task automatic rd(input logic [11:0] a, input logic [2:0] sz);
        cyc(1, 0, a, sz, 32'h0, dma_irq_in, disk_irq_in);
    endtask
    task automatic wr(input logic [11:0] a, input logic [2:0] sz, input logic [31:0] d);
        cyc(1, 1, a, sz, d, dma_irq_in, disk_irq_in);
    endtask
    task automatic idle(input logic dma, input logic disk);
        cyc(0, 0, 12'h0, 3'd4, 32'h0, dma, disk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R11: reset with interrupts high, then read back zero
        wr(12'h200, 3'd4, 32'h1234_5678);
        idle(1, 1);
        idle(0, 0);
        rst_n = 1'b1;
        rd(12'h200, 3'd4);   // R11 timing zero
        rd(12'h300, 3'd4);   // R11 irq zero
        // R5 timing write/read, wrong-size ignored
        wr(12'h200, 3'd4, 32'hA1B2_C3D4);
        rd(12'h200, 3'd4);
        wr(12'h200, 3'd2, 32'h0000_FFFF);
        wr(12'h204, 3'd1, 32'h0000_0011);
        rd(12'h20C, 3'd4);
        rd(12'h200, 3'd2);   // R8 wrong-size read
        // R2 data port sizes
        rd(12'h000, 3'd2); rd(12'h000, 3'd4);
        rd(12'h000, 3'd1); rd(12'h000, 3'd3);
        wr(12'h000, 3'd2, 32'hDEAD_BEEF); wr(12'h008, 3'd4, 32'hDEAD_BEEF);
        wr(12'h000, 3'd1, 32'h55);
        // R3 taskfile slots, with R1 low-nibble variation
        for (int i = 1; i <= 7; i++) begin
            rd(12'(i * 16 + i), 3'd1);
            wr(12'(i * 16), 3'd1, 32'hFFFF_FF00 | i);
            rd(12'(i * 16), 3'd2);
            wr(12'(i * 16), 3'd4, 32'h77);
        end
        // R4 status/command aliases
        rd(12'h080, 3'd1); rd(12'h160, 3'd1); rd(12'h16F, 3'd1);
        wr(12'h080, 3'd1, 32'hEC); wr(12'h160, 3'd1, 32'hE7);
        rd(12'h160, 3'd4);
        // R8 unmapped
        rd(12'h090, 3'd1); rd(12'h400, 3'd4); rd(12'hFF0, 3'd4); rd(12'h150, 3'd1);
        wr(12'h090, 3'd1, 32'h1);
        // R6 disk image and DMA rise/fall
        idle(0, 1); rd(12'h300, 3'd4);
        idle(1, 1); rd(12'h300, 3'd4);
        // R7 clear with bit31 zero has no effect, wrong size ignored
        wr(12'h300, 3'd4, 32'h7FFF_FFFF); rd(12'h300, 3'd4);
        wr(12'h300, 3'd2, 32'h8000_0000); rd(12'h300, 3'd4);
        wr(12'h300, 3'd4, 32'h8000_0000); rd(12'h300, 3'd4);
        // R6 fall clears, R7 rise beats clear in the same cycle
        idle(0, 0); rd(12'h300, 3'd4);
        cyc(1, 1, 12'h300, 3'd4, 32'h8000_0000, 1, 0);
        rd(12'h300, 3'd4);
        idle(0, 0); rd(12'h300, 3'd4);
        // R11 reset again mid-operation
        idle(1, 1);
        rst_n = 1'b0; idle(1, 1); rst_n = 1'b1;
        rd(12'h300, 3'd4); rd(12'h200, 3'd4);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule